// File: doc/BRIEF.md
# Loop Retransmit Elasticity Buffer

This block is a small dual-clock character queue between a receive path and a transmit path. It lets a node in a daisy chain or a ring send on the characters it receives. Received characters arrive on the recovered receive character clock. Each one is eight data bits plus a special-character flag. The transmitter pulls characters on its own local character clock, so the outbound stream carries none of the receive-side jitter.

A single loop-mode enable drives the block. It is synchronous to the transmit clock. While loop mode is on:
- every received character except the K28.5 comma/idle is stored;
- the transmitter is served from the queue;
- a K28.5 fill character is sent when the queue has nothing to give;
- the separate transmit FIFO is not read, so it can be loaded in advance.

With loop mode off, nothing received is kept and the transmitter's requests go straight to the transmit FIFO. Both queue pointers also fall back to zero, so nothing stale survives into the next loop session.

Top module: `lebuf_loop_retx`

## Requirements
- R1: The queue holds eight characters. Eight non-K28.5 characters written in loop mode with no reads in between are all kept, and all are returned later.
- R2: With loop mode off (as seen in the receive domain), received characters are not stored. A later loop session that has received nothing yields only fill characters.
- R3: A received character with the special flag at 1 and data 8'hBC (K28.5) is discarded and does not raise overflow. Other special characters, and a non-special 8'hBC, are stored with their flag.
- R4: In loop mode, a request on tx_take returns the oldest stored character, in arrival order, with tx_from_loop at 1.
- R5: In loop mode, tfifo_rd stays at 0 whatever tx_take does.
- R6: With loop mode off, tfifo_rd equals tx_take in the same cycle. The character presented on tfifo_data/tfifo_special then appears on tx_data/tx_special in the next cycle, with tx_from_loop at 0.
- R7: In loop mode with the queue empty, a request returns the fill character: tx_special 1, tx_data 8'hBC, tx_from_loop 1.
- R8: A storable character that arrives while the queue is full is dropped. rx_overflow is then high for exactly the receive clock cycle after the attempt. A stored write never happens while the queue is full.
- R9: Leaving loop mode resets both pointers, so characters left unread are never sent in a later loop session.
- R10: tx_vld is high in exactly the cycle after each cycle in which tx_take was high.
- R11: After reset, tx_vld, tx_from_loop, rx_overflow and tfifo_rd (with tx_take low) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered receive character clock |
| rx_rst_n | input | 1 | Asynchronous active-low reset, receive domain |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character data |
| rx_special | input | 1 | Received character is a special character |
| rx_overflow | output | 1 | One-cycle pulse: a character was dropped because the queue was full |
| tx_clk | input | 1 | Local transmit character clock |
| tx_rst_n | input | 1 | Asynchronous active-low reset, transmit domain |
| loop_en | input | 1 | Loop mode enable, synchronous to tx_clk |
| tx_take | input | 1 | Transmitter requests the next character |
| tx_vld | output | 1 | tx_data/tx_special hold the character answering last cycle's request |
| tx_data | output | 8 | Outgoing character data |
| tx_special | output | 1 | Outgoing character is a special character |
| tx_from_loop | output | 1 | Outgoing character came from the loop path (stored or fill) |
| tfifo_rd | output | 1 | Read request to the transmit FIFO |
| tfifo_data | input | 8 | Head character data of the transmit FIFO (first-word fall-through) |
| tfifo_special | input | 1 | Head character special flag of the transmit FIFO |

## Verification
The assertions assume a few things about the inputs:
- loop_en is driven synchronously to tx_clk.
- Once loop_en changes, it stays put long enough for the two-stage synchronizer in the receive domain and the pointer synchronizers back to settle. A change is never undone within a few cycles of the slower clock.
- Receive-side traffic that should be stored starts only after the new mode has reached the receive domain.

The stimulus follows this by waiting ten transmit cycles after every loop_en change before sending or requesting characters. Overflow is only provoked while the transmit side is idle, so the receive side's view of the read pointer is current and the full condition is exact.

// File: rtl/lebuf_pkg.sv
package lebuf_pkg;

    // Comma / idle special character used as fill and dropped on write.
    localparam logic [7:0] K28_5_CODE = 8'hBC;

    typedef struct packed {
        logic       special;
        logic [7:0] data;
    } char_t;

endpackage

// File: rtl/lebuf_sync.sv
module lebuf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/lebuf_mem.sv
module lebuf_mem
    import lebuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  char_t         wdata,
    input  logic [AW-1:0] raddr,
    output char_t         rdata
);

    char_t mem_q [DEPTH];

    // Storage has no reset: an entry is only read after it was written.
    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/lebuf_wr.sv
module lebuf_wr
    import lebuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loop_w,
    input  logic          in_valid,
    input  char_t         in_char,
    input  logic [PW-1:0] rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          overflow
);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          ovf;
    } wr_state_t;

    wr_state_t     s_d, s_q;
    logic          is_comma;
    logic          storable;
    logic [PW-1:0] bin_inc;

    always_comb begin
        s_d      = s_q;
        is_comma = in_char.special && (in_char.data == K28_5_CODE);
        storable = loop_w && in_valid && !is_comma;
        // Full: write pointer one lap ahead of the synchronized read pointer.
        full     = (s_q.gray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
        we       = storable && !full;
        bin_inc  = s_q.bin + 1'b1;

        s_d.ovf  = storable && full;
        if (!loop_w) begin
            s_d.bin  = '0;
            s_d.gray = '0;
        end else if (we) begin
            s_d.bin  = bin_inc;
            s_d.gray = bin_inc ^ (bin_inc >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign waddr    = s_q.bin[AW-1:0];
    assign wgray    = s_q.gray;
    assign overflow = s_q.ovf;

endmodule

// File: rtl/lebuf_rd.sv
module lebuf_rd
    import lebuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loop_en,
    input  logic          take,
    input  logic [PW-1:0] wgray_s,
    input  char_t         buf_char,
    input  char_t         tf_char,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          empty,
    output logic          tf_rd,
    output char_t         out_char,
    output logic          out_vld,
    output logic          out_loop
);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        char_t         ch;
        logic          vld;
        logic          from_loop;
    } rd_state_t;

    rd_state_t     s_d, s_q;
    logic [PW-1:0] bin_inc;

    always_comb begin
        s_d         = s_q;
        empty       = (s_q.gray == wgray_s);
        tf_rd       = take && !loop_en;
        bin_inc     = s_q.bin + 1'b1;

        s_d.vld       = take;
        s_d.from_loop = take && loop_en;

        if (take) begin
            if (!loop_en) begin
                s_d.ch = tf_char;
            end else if (empty) begin
                s_d.ch = '{special: 1'b1, data: K28_5_CODE};
            end else begin
                s_d.ch   = buf_char;
                s_d.bin  = bin_inc;
                s_d.gray = bin_inc ^ (bin_inc >> 1);
            end
        end

        // Flush: pointer held at zero whenever loop mode is off.
        if (!loop_en) begin
            s_d.bin  = '0;
            s_d.gray = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign raddr    = s_q.bin[AW-1:0];
    assign rgray    = s_q.gray;
    assign out_char = s_q.ch;
    assign out_vld  = s_q.vld;
    assign out_loop = s_q.from_loop;

endmodule

// File: rtl/lebuf_loop_retx.sv
module lebuf_loop_retx
    import lebuf_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic       rx_clk,
    input  logic       rx_rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_special,
    output logic       rx_overflow,
    input  logic       tx_clk,
    input  logic       tx_rst_n,
    input  logic       loop_en,
    input  logic       tx_take,
    output logic       tx_vld,
    output logic [7:0] tx_data,
    output logic       tx_special,
    output logic       tx_from_loop,
    output logic       tfifo_rd,
    input  logic [7:0] tfifo_data,
    input  logic       tfifo_special
);

    logic          loop_w;
    logic          wr_en;
    logic          wr_full;
    logic [AW-1:0] wr_addr;
    logic [PW-1:0] wr_gray;
    logic [PW-1:0] wr_gray_s;
    logic [AW-1:0] rd_addr;
    logic [PW-1:0] rd_gray;
    logic [PW-1:0] rd_gray_s;
    logic          rd_empty;
    char_t         rx_char;
    char_t         tf_char;
    char_t         mem_char;
    char_t         out_char;

    assign rx_char = '{special: rx_special, data: rx_data};
    assign tf_char = '{special: tfifo_special, data: tfifo_data};

    lebuf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_loop_sync (
        .clk(rx_clk), .rst_n(rx_rst_n), .d(loop_en), .q(loop_w)
    );

    lebuf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
        .clk(rx_clk), .rst_n(rx_rst_n), .d(rd_gray), .q(rd_gray_s)
    );

    lebuf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk(tx_clk), .rst_n(tx_rst_n), .d(wr_gray), .q(wr_gray_s)
    );

    lebuf_wr #(.DEPTH(DEPTH)) u_wr (
        .clk      (rx_clk),
        .rst_n    (rx_rst_n),
        .loop_w   (loop_w),
        .in_valid (rx_valid),
        .in_char  (rx_char),
        .rgray_s  (rd_gray_s),
        .we       (wr_en),
        .waddr    (wr_addr),
        .wgray    (wr_gray),
        .full     (wr_full),
        .overflow (rx_overflow)
    );

    lebuf_mem #(.DEPTH(DEPTH)) u_mem (
        .wr_clk (rx_clk),
        .we     (wr_en),
        .waddr  (wr_addr),
        .wdata  (rx_char),
        .raddr  (rd_addr),
        .rdata  (mem_char)
    );

    lebuf_rd #(.DEPTH(DEPTH)) u_rd (
        .clk      (tx_clk),
        .rst_n    (tx_rst_n),
        .loop_en  (loop_en),
        .take     (tx_take),
        .wgray_s  (wr_gray_s),
        .buf_char (mem_char),
        .tf_char  (tf_char),
        .raddr    (rd_addr),
        .rgray    (rd_gray),
        .empty    (rd_empty),
        .tf_rd    (tfifo_rd),
        .out_char (out_char),
        .out_vld  (tx_vld),
        .out_loop (tx_from_loop)
    );

    assign tx_data    = out_char.data;
    assign tx_special = out_char.special;

endmodule

// File: rtl/lebuf_loop_retx_chk.sv
module lebuf_loop_retx_chk #(
    parameter int PW = 4
) (
    input logic          rx_clk,
    input logic          rx_rst_n,
    input logic          rx_valid,
    input logic [7:0]    rx_data,
    input logic          rx_special,
    input logic          rx_overflow,
    input logic          loop_w,
    input logic          wr_en,
    input logic          wr_full,
    input logic [PW-1:0] wr_gray,
    input logic          tx_clk,
    input logic          tx_rst_n,
    input logic          loop_en,
    input logic          tx_take,
    input logic          tx_vld,
    input logic [7:0]    tx_data,
    input logic          tx_special,
    input logic          tx_from_loop,
    input logic          tfifo_rd,
    input logic          rd_empty,
    input logic [PW-1:0] rd_gray
);

    // R2: nothing is stored while the receive side sees loop mode off
    a_r2_no_store_outside_loop: assert property (
        @(posedge rx_clk) disable iff (!rx_rst_n) !loop_w |-> !wr_en);

    // R3: a K28.5 arrival leaves the write pointer where it was
    a_r3_comma_not_stored: assert property (
        @(posedge rx_clk) disable iff (!rx_rst_n)
        (rx_valid && rx_special && rx_data == 8'hBC && loop_w) |=> $stable(wr_gray));

    // R8: overflow only follows an attempt against a full queue
    a_r8_ovf_after_full_attempt: assert property (
        @(posedge rx_clk) disable iff (!rx_rst_n)
        rx_overflow |-> $past(rx_valid && wr_full && loop_w));

    // R8: no storage write while full
    a_r8_no_write_when_full: assert property (
        @(posedge rx_clk) disable iff (!rx_rst_n) wr_en |-> !wr_full);

    // R5: the transmit FIFO is left alone in loop mode
    a_r5_no_tfifo_read_in_loop: assert property (
        @(posedge tx_clk) disable iff (!tx_rst_n) loop_en |-> !tfifo_rd);

    // R6: a normal-mode request is answered from the transmit FIFO path
    a_r6_normal_source: assert property (
        @(posedge tx_clk) disable iff (!tx_rst_n)
        (tx_take && !loop_en) |=> (tx_vld && !tx_from_loop));

    // R7: empty loop request yields the fill character
    a_r7_fill_when_empty: assert property (
        @(posedge tx_clk) disable iff (!tx_rst_n)
        (tx_take && loop_en && rd_empty) |=>
        (tx_special && tx_data == 8'hBC && tx_from_loop));

    // R9: read pointer held at zero outside loop mode
    a_r9_flush_read_ptr: assert property (
        @(posedge tx_clk) disable iff (!tx_rst_n) !loop_en |=> (rd_gray == '0));

    // R10: one answer per request, one cycle later
    a_r10_vld_on_take: assert property (
        @(posedge tx_clk) disable iff (!tx_rst_n) tx_take |=> tx_vld);

    a_r10_no_vld_without_take: assert property (
        @(posedge tx_clk) disable iff (!tx_rst_n) !tx_take |=> !tx_vld);

endmodule

bind lebuf_loop_retx lebuf_loop_retx_chk #(.PW(PW)) u_chk (
    .rx_clk       (rx_clk),
    .rx_rst_n     (rx_rst_n),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_special   (rx_special),
    .rx_overflow  (rx_overflow),
    .loop_w       (loop_w),
    .wr_en        (wr_en),
    .wr_full      (wr_full),
    .wr_gray      (wr_gray),
    .tx_clk       (tx_clk),
    .tx_rst_n     (tx_rst_n),
    .loop_en      (loop_en),
    .tx_take      (tx_take),
    .tx_vld       (tx_vld),
    .tx_data      (tx_data),
    .tx_special   (tx_special),
    .tx_from_loop (tx_from_loop),
    .tfifo_rd     (tfifo_rd),
    .rd_empty     (rd_empty),
    .rd_gray      (rd_gray)
);

// File: tb/tb_lebuf_loop_retx.sv
module tb_lebuf_loop_retx;

    localparam int DEPTH = 8;

    logic       rx_clk = 1'b0;
    logic       tx_clk = 1'b0;
    logic       rx_rst_n = 1'b0;
    logic       tx_rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_special = 1'b0;
    logic       rx_overflow;
    logic       loop_en = 1'b0;
    logic       tx_take = 1'b0;
    logic       tx_vld;
    logic [7:0] tx_data;
    logic       tx_special;
    logic       tx_from_loop;
    logic       tfifo_rd;
    logic [7:0] tfifo_data = 8'h40;
    logic       tfifo_special = 1'b0;

    int   checks = 0;
    int   errors = 0;
    int   fill_cnt = 0;
    bit   loop_on = 1'b0;
    bit   done = 1'b0;
    logic [8:0] sb_q [$];

    always #10ns tx_clk = ~tx_clk;   // 50 MHz transmit clock
    always #7ns  rx_clk = ~rx_clk;   // unrelated receive clock

    lebuf_loop_retx #(.DEPTH(DEPTH)) dut (
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_special(rx_special), .rx_overflow(rx_overflow),
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .loop_en(loop_en),
        .tx_take(tx_take), .tx_vld(tx_vld), .tx_data(tx_data),
        .tx_special(tx_special), .tx_from_loop(tx_from_loop),
        .tfifo_rd(tfifo_rd), .tfifo_data(tfifo_data), .tfifo_special(tfifo_special)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: one received character; pushes the expected stored item.
    task automatic rx_put(input logic [7:0] d, input logic sp);
        bit comma;
        bit exp_ovf;
        comma   = sp && (d == 8'hBC);
        exp_ovf = loop_on && !comma && (sb_q.size() >= DEPTH);
        if (loop_on && !comma && !exp_ovf) sb_q.push_back({sp, d});
        @(negedge rx_clk);
        rx_valid   = 1'b1;
        rx_data    = d;
        rx_special = sp;
        @(negedge rx_clk);
        rx_valid = 1'b0;
        chk(rx_overflow == exp_ovf, "R8", "rx_overflow", int'(rx_overflow), int'(exp_ovf));
    endtask

    // One transmit request; checks source select and answer timing.
    task automatic tx_req();
        logic [8:0] exp_tf;
        @(negedge tx_clk);
        tx_take = 1'b1;
        exp_tf  = {tfifo_special, tfifo_data};
        #1ns;
        if (loop_on) chk(tfifo_rd == 1'b0, "R5", "tfifo_rd in loop", int'(tfifo_rd), 0);
        else         chk(tfifo_rd == 1'b1, "R6", "tfifo_rd normal", int'(tfifo_rd), 1);
        @(negedge tx_clk);
        tx_take = 1'b0;
        chk(tx_vld == 1'b1, "R10", "tx_vld after take", int'(tx_vld), 1);
        if (!loop_on) begin
            chk({tx_special, tx_data} == exp_tf, "R6", "tfifo char", int'({tx_special, tx_data}), int'(exp_tf));
            chk(tx_from_loop == 1'b0, "R6", "tx_from_loop", int'(tx_from_loop), 0);
            tfifo_data = tfifo_data + 8'd1;
        end
        #1ns;
    endtask

    task automatic set_loop(input bit on);
        @(negedge tx_clk);
        loop_en = on;
        loop_on = on;
        if (!on) sb_q.delete();   // R9: unread items are flushed
        repeat (10) @(negedge tx_clk);
    endtask

    // Monitor / scoreboard on the loop path.
    always @(negedge tx_clk) begin
        if (tx_rst_n && tx_vld && tx_from_loop) begin
            if (tx_special && tx_data == 8'hBC) begin
                fill_cnt++;
            end else if (sb_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected loop char", int'({tx_special, tx_data}), 0);
            end else begin
                logic [8:0] exp;
                exp = sb_q.pop_front();
                chk({tx_special, tx_data} == exp, "R4", "loop char order",
                    int'({tx_special, tx_data}), int'(exp));
            end
        end
    end

    initial begin
        #4ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (3) @(negedge tx_clk);
        rx_rst_n = 1'b1;
        tx_rst_n = 1'b1;
        @(negedge tx_clk);
        // R11 reset state
        chk(tx_vld == 1'b0, "R11", "tx_vld", int'(tx_vld), 0);
        chk(tx_from_loop == 1'b0, "R11", "tx_from_loop", int'(tx_from_loop), 0);
        chk(rx_overflow == 1'b0, "R11", "rx_overflow", int'(rx_overflow), 0);
        chk(tfifo_rd == 1'b0, "R11", "tfifo_rd", int'(tfifo_rd), 0);

        // R6 normal mode from transmit FIFO
        tfifo_special = 1'b1;
        tx_req();
        tfifo_special = 1'b0;
        tx_req();
        tx_req();

        // R2 characters received outside loop mode are not kept
        rx_put(8'h11, 1'b0);
        rx_put(8'h22, 1'b0);
        set_loop(1'b1);
        f0 = fill_cnt;
        tx_req();
        tx_req();
        chk(fill_cnt == f0 + 2, "R2", "fills after idle entry", fill_cnt - f0, 2);

        // R3 / R4 comma dropped, other specials kept, order preserved
        rx_put(8'hA1, 1'b0);
        rx_put(8'hBC, 1'b1);
        rx_put(8'h3C, 1'b1);
        rx_put(8'hBC, 1'b0);
        rx_put(8'h55, 1'b0);
        chk(sb_q.size() == 4, "R3", "stored count model", sb_q.size(), 4);
        repeat (10) @(negedge tx_clk);
        f0 = fill_cnt;
        repeat (4) tx_req();
        chk(sb_q.size() == 0, "R4", "all loop chars delivered", sb_q.size(), 0);
        chk(fill_cnt == f0, "R3", "no fill before drain", fill_cnt - f0, 0);
        // R7 empty queue gives fill
        tx_req();
        chk(fill_cnt == f0 + 1, "R7", "fill when empty", fill_cnt - f0, 1);

        // R1 / R8 fill to depth, then overflow; comma while full is no overflow
        for (int i = 0; i < DEPTH + 2; i++) rx_put(8'h80 + 8'(i), 1'b0);
        rx_put(8'hBC, 1'b1);
        chk(sb_q.size() == DEPTH, "R1", "kept characters", sb_q.size(), DEPTH);
        repeat (10) @(negedge tx_clk);
        f0 = fill_cnt;
        repeat (DEPTH + 1) tx_req();
        chk(sb_q.size() == 0, "R1", "eight returned", sb_q.size(), 0);
        chk(fill_cnt == f0 + 1, "R8", "dropped chars not sent", fill_cnt - f0, 1);

        // R9 flush on leaving loop mode
        rx_put(8'hD1, 1'b0);
        rx_put(8'hD2, 1'b0);
        rx_put(8'hD3, 1'b0);
        repeat (10) @(negedge tx_clk);
        set_loop(1'b0);
        tx_req();   // R6 resumes the transmit FIFO
        set_loop(1'b1);
        f0 = fill_cnt;
        tx_req();
        tx_req();
        chk(fill_cnt == f0 + 2, "R9", "no stale chars after flush", fill_cnt - f0, 2);

        // R10 no answer without a request
        repeat (2) @(negedge tx_clk);
        chk(tx_vld == 1'b0, "R10", "tx_vld idle", int'(tx_vld), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule